// File: doc/BRIEF.md
# Decimal Accumulator Processor

A small stored-program processor built entirely on decimal words. Each word is three BCD digits (twelve bits, no sign). A memory of one hundred such words is addressed by a two-digit BCD address. Data passes through a single accumulator. A two-digit BCD program counter steps through the memory. Arithmetic is limited to adding a memory word to the accumulator or subtracting one from it, modulo 1000, with a decimal carry or borrow between digits. Only arithmetic updates three indicators: negative, zero and positive-or-zero. Conditional flow uses instructions that skip the next word when an indicator is set. There are no conditional jumps.

While the processor is halted, a loader writes the program and its data into memory through a write port. A one-cycle `start` pulse then runs the program from the current counter value. A halt instruction stops the program and leaves the counter pointing at the word after the halt. A later `start` continues from that point. Input uses a valid/ready handshake into the accumulator. Output presents the accumulator on `out_data` with a one-cycle strobe.

The controller is a four-state machine with these states:
- `ST_HALT` (halted) moves to `ST_FETCH` on `start`.
- `ST_FETCH` latches the word at the counter and increments the counter, then moves to `ST_EXEC`.
- `ST_EXEC` performs the latched instruction. It moves to `ST_HALT` for a halt, to `ST_INPUT` for an input, and to `ST_FETCH` otherwise.
- `ST_INPUT` waits with `in_ready` high and moves to `ST_FETCH` once `in_valid` is seen.

Top module: `dec_acc_cpu`

## Requirements
- R1: After reset the processor is halted. The counter reads 00, the accumulator is 000, negative is 0, zero is 1 and positive-or-zero is 1. `in_ready` and `out_strobe` are low.
- R2: A loader write stores `load_data` at `load_addr` only while `halted` is high. A write made while running is ignored. The address is BCD with tens in bits [7:4] and units in bits [3:0]. The data digits are hundreds [11:8], tens [7:4] and units [3:0].
- R3: The instruction cycle works as follows. A `start` pulse while halted enters `ST_FETCH`. Fetch latches the word at the counter and adds one to the counter, wrapping 99 to 00. Execute then acts on the opcode in the hundreds digit. The other two digits are an address or an extension.
- R4: Opcode 0 halts. While halted, the counter and `halted` hold until `start` arrives, and execution resumes at the word after the halt.
- R5: Opcode 1 (ADD) sets the accumulator to (accumulator + mem[xx]) mod 1000 with decimal carries. It clears negative, sets positive-or-zero, and sets zero exactly when the result is 000.
- R6: Opcode 2 (SUBT) sets the accumulator to (accumulator - mem[xx]) mod 1000. Negative is set and positive-or-zero is cleared exactly when the subtraction borrows out of the hundreds digit. Zero is set exactly when the result is 000.
- R7: Opcode 3 writes the accumulator to mem[xx]. Opcode 5 loads mem[xx] into the accumulator. Neither changes any indicator.
- R8: Opcode 6 sets the counter to xx unconditionally.
- R9: Opcode 7 skips the next word in three cases: extension 00 when negative is set, extension 01 when zero is set, and extension 02 when positive-or-zero is set. With any other extension, or when the indicator is clear, execution goes on to the next word.
- R10: Opcode 9 with extension 01 raises `in_ready` and holds it until `in_valid` is seen. On that cycle `in_data` enters the accumulator and no indicator changes.
- R11: Opcode 9 with extension 02 presents the accumulator on `out_data` with `out_strobe` high for exactly one cycle, one cycle after execute.
- R12: Opcodes 4 and 8, and opcode 9 with any extension other than 01 or 02, do nothing and execution continues with the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Leaves the halted state |
| load_we | input | 1 | Loader write enable (honoured only while halted) |
| load_addr | input | 8 | Loader BCD address |
| load_data | input | 12 | Loader BCD word |
| in_valid | input | 1 | Input word available |
| in_data | input | 12 | Input BCD word |
| in_ready | output | 1 | Processor waiting for an input word |
| out_strobe | output | 1 | One-cycle output strobe |
| out_data | output | 12 | Output BCD word |
| halted | output | 1 | Processor is in the halted state |
| pc_o | output | 8 | Program counter, BCD |
| flag_neg | output | 1 | Negative indicator |
| flag_zero | output | 1 | Zero indicator |
| flag_pos | output | 1 | Positive-or-zero indicator |

## Verification
On every cycle the assertions check several invariants:
- Negative and positive-or-zero are always complementary, and zero implies positive-or-zero.
- The output strobe never lasts more than one cycle.
- `in_ready` holds until the handshake, and the accepted word is what lands in the accumulator.
- A halted processor keeps its counter.
- A load leaves the indicators unchanged, and a jump lands on its address.

Some behaviour can only be shown by the bench's programs:
- the decimal values of wrapped sums and borrowed differences;
- which skips are taken and which are not;
- the counter wrapping from 99 to 00;
- loader writes being ignored while the program runs.

// File: rtl/dac_pkg.sv
package dac_pkg;

    typedef enum logic [1:0] {
        ST_HALT,
        ST_FETCH,
        ST_EXEC,
        ST_INPUT
    } dac_state_e;

    localparam logic [3:0] OP_HALT  = 4'd0;
    localparam logic [3:0] OP_ADD   = 4'd1;
    localparam logic [3:0] OP_SUB   = 4'd2;
    localparam logic [3:0] OP_STORE = 4'd3;
    localparam logic [3:0] OP_LOAD  = 4'd5;
    localparam logic [3:0] OP_JUMP  = 4'd6;
    localparam logic [3:0] OP_SKIP  = 4'd7;
    localparam logic [3:0] OP_IO    = 4'd9;

    // extension codes (value of the low digits)
    localparam int EXT_IF_NEG  = 0;
    localparam int EXT_IF_ZERO = 1;
    localparam int EXT_IF_POS  = 2;
    localparam int EXT_READ    = 1;
    localparam int EXT_WRITE   = 2;

endpackage

// File: rtl/dac_bcd_digit.sv
module dac_bcd_digit (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       sub,
    input  logic       cin,
    output logic [3:0] y,
    output logic       cout
);

    logic [4:0] t;

    always_comb begin
        if (!sub) begin
            t = {1'b0, a} + {1'b0, b} + {4'b0, cin};
            if (t > 5'd9) begin
                y    = 4'(t - 5'd10);
                cout = 1'b1;
            end else begin
                y    = t[3:0];
                cout = 1'b0;
            end
        end else begin
            t = {1'b0, a} - {1'b0, b} - {4'b0, cin};
            if (t[4]) begin
                y    = 4'(t + 5'd10);
                cout = 1'b1;
            end else begin
                y    = t[3:0];
                cout = 1'b0;
            end
        end
    end

endmodule

// File: rtl/dac_bcd_addsub.sv
module dac_bcd_addsub #(
    parameter int NDIG = 3
) (
    input  logic [4*NDIG-1:0] a,
    input  logic [4*NDIG-1:0] b,
    input  logic              sub,
    output logic [4*NDIG-1:0] y,
    output logic              cout
);

    logic [NDIG:0] c;

    assign c[0] = 1'b0;
    assign cout = c[NDIG];

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        dac_bcd_digit u_dig (
            .a    (a[4*i +: 4]),
            .b    (b[4*i +: 4]),
            .sub  (sub),
            .cin  (c[i]),
            .y    (y[4*i +: 4]),
            .cout (c[i+1])
        );
    end

endmodule

// File: rtl/dac_bcd_inc.sv
module dac_bcd_inc #(
    parameter int NDIG = 2
) (
    input  logic [4*NDIG-1:0] a,
    output logic [4*NDIG-1:0] y
);

    logic [NDIG-1:0] c;

    assign c[0] = 1'b1;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic nine;
        assign nine = (a[4*i +: 4] == 4'd9);
        assign y[4*i +: 4] = (c[i] && nine) ? 4'd0 : a[4*i +: 4] + {3'b0, c[i]};
        if (i < NDIG - 1) begin : g_carry
            assign c[i+1] = c[i] && nine;
        end
    end

endmodule

// File: rtl/dac_mem.sv
module dac_mem #(
    parameter int WORD_W   = 12,
    parameter int ADDR_DIG = 2
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [4*ADDR_DIG-1:0] waddr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [4*ADDR_DIG-1:0] raddr,
    output logic [WORD_W-1:0]     rdata
);

    localparam int DEPTH = 10 ** ADDR_DIG;
    localparam int IW    = $clog2(DEPTH);

    logic [WORD_W-1:0] mem [DEPTH];

    function automatic int idx_of(input logic [4*ADDR_DIG-1:0] a);
        int r;
        r = 0;
        for (int i = ADDR_DIG - 1; i >= 0; i--) begin
            r = r * 10 + int'(a[4*i +: 4]);
        end
        return r;
    endfunction

    int             widx, ridx;
    logic [IW-1:0]  wsel, rsel;

    assign widx = idx_of(waddr);
    assign ridx = idx_of(raddr);
    assign wsel = IW'(widx);
    assign rsel = IW'(ridx);

    always_ff @(posedge clk) begin
        if (we && widx < DEPTH) begin
            mem[wsel] <= wdata;
        end
    end

    assign rdata = (ridx < DEPTH) ? mem[rsel] : '0;

endmodule

// File: rtl/dec_acc_cpu.sv
module dec_acc_cpu #(
    parameter int WORD_DIG = 3,
    parameter int ADDR_DIG = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  load_we,
    input  logic [4*ADDR_DIG-1:0] load_addr,
    input  logic [4*WORD_DIG-1:0] load_data,
    input  logic                  in_valid,
    input  logic [4*WORD_DIG-1:0] in_data,
    output logic                  in_ready,
    output logic                  out_strobe,
    output logic [4*WORD_DIG-1:0] out_data,
    output logic                  halted,
    output logic [4*ADDR_DIG-1:0] pc_o,
    output logic                  flag_neg,
    output logic                  flag_zero,
    output logic                  flag_pos
);

    import dac_pkg::*;

    localparam int WORD_W = 4 * WORD_DIG;
    localparam int ADDR_W = 4 * ADDR_DIG;

    dac_state_e        state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_inc;
    logic [WORD_W-1:0] ir_q, acc_q;
    logic [WORD_W-1:0] mem_rdata, alu_y;
    logic              alu_bw;
    logic              neg_q, zero_q, pos_q;

    logic [3:0]        opcode;
    logic [ADDR_W-1:0] field;
    logic              in_exec, do_sub, skip_take;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [WORD_W-1:0] mem_wdata;

    assign opcode  = ir_q[WORD_W-1 -: 4];
    assign field   = ir_q[ADDR_W-1:0];
    assign in_exec = (state_q == ST_EXEC);
    assign do_sub  = (opcode == OP_SUB);

    // memory ports: loader owns the write port only while halted
    always_comb begin
        if (state_q == ST_HALT) begin
            mem_we    = load_we;
            mem_waddr = load_addr;
            mem_wdata = load_data;
        end else begin
            mem_we    = in_exec && (opcode == OP_STORE);
            mem_waddr = field;
            mem_wdata = acc_q;
        end
        mem_raddr = (state_q == ST_FETCH) ? pc_q : field;
    end

    dac_mem #(.WORD_W(WORD_W), .ADDR_DIG(ADDR_DIG)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    dac_bcd_addsub #(.NDIG(WORD_DIG)) u_alu (
        .a    (acc_q),
        .b    (mem_rdata),
        .sub  (do_sub),
        .y    (alu_y),
        .cout (alu_bw)
    );

    dac_bcd_inc #(.NDIG(ADDR_DIG)) u_pc_inc (
        .a (pc_q),
        .y (pc_inc)
    );

    always_comb begin
        if (field == ADDR_W'(EXT_IF_NEG))       skip_take = neg_q;
        else if (field == ADDR_W'(EXT_IF_ZERO)) skip_take = zero_q;
        else if (field == ADDR_W'(EXT_IF_POS))  skip_take = pos_q;
        else                                    skip_take = 1'b0;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (start) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_EXEC;
            ST_EXEC: begin
                if (opcode == OP_HALT)
                    state_d = ST_HALT;
                else if (opcode == OP_IO && field == ADDR_W'(EXT_READ))
                    state_d = ST_INPUT;
                else
                    state_d = ST_FETCH;
            end
            ST_INPUT: if (in_valid) state_d = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            ir_q   <= '0;
            acc_q  <= '0;
            neg_q  <= 1'b0;
            zero_q <= 1'b1;
            pos_q  <= 1'b1;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_inc;
                end
                ST_EXEC: begin
                    case (opcode)
                        OP_ADD, OP_SUB: begin
                            acc_q  <= alu_y;
                            neg_q  <= do_sub && alu_bw;
                            pos_q  <= !(do_sub && alu_bw);
                            zero_q <= (alu_y == '0);
                        end
                        OP_LOAD: acc_q <= mem_rdata;
                        OP_JUMP: pc_q  <= field;
                        OP_SKIP: if (skip_take) pc_q <= pc_inc;
                        default: ;
                    endcase
                end
                ST_INPUT: if (in_valid) acc_q <= in_data;
                ST_HALT: ;
            endcase
        end
    end

    // output port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_strobe <= 1'b0;
            out_data   <= '0;
        end else begin
            out_strobe <= in_exec && opcode == OP_IO && field == ADDR_W'(EXT_WRITE);
            if (in_exec && opcode == OP_IO && field == ADDR_W'(EXT_WRITE))
                out_data <= acc_q;
        end
    end

    assign halted    = (state_q == ST_HALT);
    assign in_ready  = (state_q == ST_INPUT);
    assign pc_o      = pc_q;
    assign flag_neg  = neg_q;
    assign flag_zero = zero_q;
    assign flag_pos  = pos_q;

    // R6
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_neg != flag_pos);

    // R5
    zero_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero |-> flag_pos);

    // R11
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |=> !out_strobe);

    // R10
    in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && !in_valid |=> in_ready);

    // R10
    in_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready && in_valid |=> !in_ready && acc_q == $past(in_data));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !start |=> halted && $stable(pc_o));

    // R7
    load_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec && opcode == OP_LOAD |=> $stable(flag_neg) && $stable(flag_zero) && $stable(flag_pos));

    // R8
    jump_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_exec && opcode == OP_JUMP |=> pc_o == $past(field));

endmodule

// File: tb/dec_acc_cpu_tb.sv
`timescale 1ns/1ps
module dec_acc_cpu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        load_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [11:0] load_data = '0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_ready, out_strobe, halted;
    logic [11:0] out_data;
    logic [7:0]  pc_o;
    logic        flag_neg, flag_zero, flag_pos;

    int n_cmp  = 0;
    int n_bad  = 0;
    logic [11:0] exp_q[$];

    always #2.5 clk = ~clk;

    dec_acc_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_strobe(out_strobe), .out_data(out_data), .halted(halted),
        .pc_o(pc_o), .flag_neg(flag_neg), .flag_zero(flag_zero), .flag_pos(flag_pos)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input logic [11:0] v);
        exp_q.push_back(v);
    endtask

    // monitor: scoreboard comparison of output strobes
    always @(negedge clk) begin
        if (rst_n && out_strobe) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 unexpected output", int'(out_data), 0);
            end else begin
                logic [11:0] e;
                e = exp_q.pop_front();
                chk(out_data == e, "R11 output word", int'(out_data), int'(e));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [11:0] d);
        @(negedge clk);
        load_we = 1'b1; load_addr = a; load_data = d;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic run_to_halt();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        do @(negedge clk); while (!halted);
    endtask

    task automatic chk_flags(input string tag, input bit n, input bit z, input bit p);
        chk({flag_neg, flag_zero, flag_pos} == {n, z, p}, tag,
            int'({flag_neg, flag_zero, flag_pos}), int'({n, z, p}));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(halted == 1'b1, "R1 halted", int'(halted), 1);
        chk(pc_o == 8'h00, "R1 pc", int'(pc_o), 0);
        chk_flags("R1 flags", 1'b0, 1'b1, 1'b1);
        chk(!in_ready && !out_strobe, "R1 handshake idle", int'({in_ready, out_strobe}), 0);

        // program A: input, add wrap, sub borrow, skips, store/load, no-ops, jump
        wr(8'h00, 12'h901); wr(8'h01, 12'h902); wr(8'h02, 12'h120); wr(8'h03, 12'h902);
        wr(8'h04, 12'h221); wr(8'h05, 12'h700); wr(8'h06, 12'h000); wr(8'h07, 12'h902);
        wr(8'h08, 12'h330); wr(8'h09, 12'h222); wr(8'h10, 12'h701); wr(8'h11, 12'h000);
        wr(8'h12, 12'h530); wr(8'h13, 12'h902); wr(8'h14, 12'h702); wr(8'h15, 12'h000);
        wr(8'h16, 12'h703); wr(8'h17, 12'h400); wr(8'h18, 12'h903); wr(8'h19, 12'h690);
        wr(8'h20, 12'h900); wr(8'h21, 12'h050); wr(8'h22, 12'h973); wr(8'h90, 12'h000);
        expect_out(12'h123);  // R10 input then output
        expect_out(12'h023);  // R5 123+900 wraps
        expect_out(12'h973);  // R6 023-050 borrows, R9 skip on negative
        expect_out(12'h973);  // R7 store then load back
        in_valid = 1'b1; in_data = 12'h123;
        run_to_halt();
        in_valid = 1'b0;
        // R8 jump to 90, halt there; R12 opcodes 4 and 903 fell through; R9 703 no skip
        chk(pc_o == 8'h91, "R8 R12 pc after jump and halt", int'(pc_o), 'h91);
        // R7 load after zero result leaves zero set
        chk_flags("R7 flags kept over load", 1'b0, 1'b1, 1'b1);
        chk(exp_q.size() == 0, "R9 all outputs seen", exp_q.size(), 0);

        // R4 resume after halt
        wr(8'h91, 12'h902); wr(8'h92, 12'h000);
        expect_out(12'h973);
        run_to_halt();
        chk(pc_o == 8'h93, "R4 resume pc", int'(pc_o), 'h93);
        chk(exp_q.size() == 0, "R4 output seen", exp_q.size(), 0);

        // R10 wait for input, R2 loader ignored while running
        wr(8'h93, 12'h901); wr(8'h94, 12'h000);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        do @(negedge clk); while (!in_ready);
        chk(!halted, "R10 running while waiting", int'(halted), 0);
        wr(8'h94, 12'h902);
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R10 ready holds", int'(in_ready), 1);
        in_valid = 1'b1; in_data = 12'h456;
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R10 ready drops", int'(in_ready), 0);
        do @(negedge clk); while (!halted);
        chk(pc_o == 8'h95, "R2 write ignored, halt kept", int'(pc_o), 'h95);
        chk(exp_q.size() == 0, "R2 no output", exp_q.size(), 0);

        // R3 counter wrap 99->00, R5 add to exactly 000
        wr(8'h95, 12'h140); wr(8'h96, 12'h699); wr(8'h40, 12'h544);
        wr(8'h99, 12'h902); wr(8'h00, 12'h000);
        expect_out(12'h000);
        run_to_halt();
        chk(pc_o == 8'h01, "R3 pc wrap", int'(pc_o), 'h01);
        chk_flags("R5 sum zero flags", 1'b0, 1'b1, 1'b1);

        // R6 borrow from 000, R9 skips not taken
        wr(8'h01, 12'h241); wr(8'h41, 12'h001); wr(8'h02, 12'h902); wr(8'h03, 12'h701);
        wr(8'h04, 12'h902); wr(8'h05, 12'h702); wr(8'h06, 12'h902); wr(8'h07, 12'h000);
        expect_out(12'h999); expect_out(12'h999); expect_out(12'h999);
        run_to_halt();
        chk(pc_o == 8'h08, "R9 skips not taken", int'(pc_o), 'h08);
        chk_flags("R6 borrow flags", 1'b1, 1'b0, 1'b0);
        chk(exp_q.size() == 0, "R6 outputs seen", exp_q.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule